// File: doc/BRIEF.md
# Four-state hard-decision Viterbi decoder with wrapping path metrics

The block decodes a rate-1/2 convolutional code with memory 2, so the trellis has four states. Each cycle with `in_valid` high delivers one received pair of hard bits. From that pair the block forms a Hamming-distance branch metric for every branch. It then runs add-compare-select for all four states within the same cycle.

Path metrics sit in narrow registers that are never rescaled or cleared in operation. They wrap modulo 2^W. Comparisons use the sign bit of the W-bit difference, which gives the right order as long as the true spread between metrics stays under half the modulus.

Each state keeps its survivor path as a row of decoded bits in a register-exchange array. Once the decision depth has been reached, every accepted symbol yields one decoded bit: the oldest bit in the row of the state with the best metric. A receiver feeds the hard-decided pairs straight in and takes the decoded bit stream, which lags the input by a fixed number of symbols.

Top module: `vit_decoder`

## Requirements
- R1: Symbols follow the encoder convention. `in_sym[1]` is the XOR of the current, previous and second-previous input bits (polynomial 7). `in_sym[0]` is the XOR of the current and second-previous bits (polynomial 5). For an error-free stream that starts from the all-zero encoder state, the decoded bits equal the encoder input bits.
- R2: Branch metrics are the Hamming distance, 0 to 2, between the received pair and each branch's expected pair. A single flipped bit in a symbol, with at least 20 clean symbols on either side, is corrected.
- R3: Path metrics are W = 4 bits wide and wrap modulo 16 without rescaling. Every compare takes the sign of the modular difference. The spread between any two state metrics never exceeds 6. Decisions match those of a decoder that uses unbounded integer metrics, over long noisy streams.
- R4: Reset (active-low, synchronous) sets the metric of state 0 to 0 and the metrics of the other states to 4, clears all survivor rows and the symbol count, and holds `out_valid` low.
- R5: `out_valid` is high in exactly the cycle after each accepted symbol, starting from the 12th accepted symbol since reset, and low in every other cycle.
- R6: A cycle with `in_valid` low changes no metric, survivor or count, and leaves `out_bit` stable. A stream broken by idle gaps decodes to the same bits as an unbroken one.
- R7: When the two candidate metrics for a state are equal, the survivor comes from the lower-numbered predecessor. When state metrics tie for the best, the lowest-numbered state is chosen. A state number has the newest input bit as its MSB.
- R8: With DEPTH = 12, `out_bit` is the oldest bit of the best state's survivor row. After the k-th accepted symbol (k ≥ 12), it is the decision on the input bit of symbol k−11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A received symbol is present on `in_sym` this cycle |
| in_sym | input | 2 | Received hard-bit pair: bit 1 from polynomial 7, bit 0 from polynomial 5 |
| out_valid | output | 1 | `out_bit` carries a new decoded bit |
| out_bit | output | 1 | Decoded bit for the symbol 11 positions before the latest one |

## Verification
Every result of this block is due one cycle after the rising edge that accepts a symbol. On that edge the metrics, the survivor rows and the count are all updated, and the outputs decode from those registers. The bench drives each symbol on a falling edge and advances its behavioural integer-metric model at the same moment. At the next falling edge it compares `out_valid` and `out_bit` with what the model predicted, before it drives anything new. A decoded bit refers to the symbol eleven accepted positions back, so the bench checks against the encoder's input bit at that position. Idle cycles advance nothing in the model, so gaps shift no expectation.

// File: rtl/vit_pkg.sv
// Shared trellis constants and helpers for the four-state decoder.
// Assumes a rate-1/2, memory-2 code; a state number holds the newest
// input bit in its MSB.
package vit_pkg;
    localparam int MEM    = 2;
    localparam int NSTATE = 1 << MEM;
    localparam int NCODE  = 4;
    localparam logic [MEM:0] POLY_A = 3'b111;
    localparam logic [MEM:0] POLY_B = 3'b101;

    // Expected coded pair when input bit u leaves state prev.
    function automatic logic [1:0] code_of(input logic u, input int prev);
        logic [MEM:0] r;
        r = {u, prev[MEM-1:0]};
        return {^(r & POLY_A), ^(r & POLY_B)};
    endfunction

    // Predecessor of state s; b picks the one whose oldest bit is 1.
    function automatic int pred_of(input int s, input logic b);
        return ((s * 2) % NSTATE) + int'(b);
    endfunction

    // Input bit that drives the trellis into state s.
    function automatic logic in_bit_of(input int s);
        return s >= (NSTATE / 2);
    endfunction
endpackage

// File: rtl/vit_branch_metric.sv
// Hamming-distance branch metrics for one received hard pair against
// every possible coded pair. Purely combinational; the output index is
// the coded pair value.
module vit_branch_metric
    import vit_pkg::*;
(
    input  logic [1:0] rx,
    output logic [1:0] bm [NCODE]
);
    for (genvar c = 0; c < NCODE; c++) begin : g_code
        localparam logic [1:0] CV = 2'(c);
        // Count the bits in which the received pair differs from code c.
        always_comb bm[c] = {1'b0, rx[1] ^ CV[1]} + {1'b0, rx[0] ^ CV[0]};
    end
endmodule

// File: rtl/vit_acs_unit.sv
// Add-compare-select for one state. Candidate metrics wrap modulo 2^W.
// The winner is decided by the sign of their modular difference, which
// assumes the true spread stays under 2^(W-1). A tie keeps predecessor a,
// the lower-numbered one.
module vit_acs_unit #(
    parameter int W = 4
) (
    input  logic [W-1:0] pm_a,
    input  logic [W-1:0] pm_b,
    input  logic [1:0]   bm_a,
    input  logic [1:0]   bm_b,
    output logic [W-1:0] pm_new,
    output logic         pick
);
    logic [W-1:0] cand_a, cand_b, gap;

    // Extend the branch metrics and add them to the predecessor metrics.
    always_comb begin
        cand_a = pm_a + {{(W-2){1'b0}}, bm_a};
        cand_b = pm_b + {{(W-2){1'b0}}, bm_b};
        gap    = cand_b - cand_a;
    end

    // Take b only when its candidate is strictly smaller in modular order.
    always_comb begin
        pick   = gap[W-1];
        pm_new = pick ? cand_b : cand_a;
    end
endmodule

// File: rtl/vit_survivor.sv
// Register-exchange survivor store. Each state's row takes the row of its
// chosen predecessor, shifted up by one, with the state's own input bit
// entering at bit 0. Bit DEPTH-1 holds the oldest decision.
module vit_survivor
    import vit_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pick [NSTATE],
    output logic [DEPTH-1:0] rows [NSTATE]
);
    // Clear on reset; exchange all rows on each accepted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSTATE; s++) rows[s] <= '0;
        end else if (en) begin
            for (int s = 0; s < NSTATE; s++)
                rows[s] <= {rows[pred_of(s, pick[s])][DEPTH-2:0], in_bit_of(s)};
        end
    end
endmodule

// File: rtl/vit_decoder.sv
// Top level of the hard-decision decoder. It accepts one received pair
// per valid cycle and updates all four path metrics in that cycle. The
// metrics wrap freely and are never rescaled. After DEPTH symbols it
// emits one decoded bit per accepted symbol, one cycle after acceptance.
// Assumes W is large enough that 2^(W-1) exceeds the metric spread (6).
module vit_decoder
    import vit_pkg::*;
#(
    parameter int W           = 4,
    parameter int DEPTH       = 12,
    parameter int INIT_OFFSET = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] in_sym,
    output logic       out_valid,
    output logic       out_bit
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [1:0]       bm    [NCODE];
    logic [W-1:0]     pm_q  [NSTATE];
    logic [W-1:0]     pm_d  [NSTATE];
    logic             pick  [NSTATE];
    logic [DEPTH-1:0] rows  [NSTATE];
    logic [CW-1:0]    cnt_q;
    logic             valid_q;
    logic [MEM-1:0]   best;
    logic [W-1:0]     best_gap;

    vit_branch_metric u_bm (
        .rx (in_sym),
        .bm (bm)
    );

    for (genvar s = 0; s < NSTATE; s++) begin : g_acs
        localparam int         PA = pred_of(s, 1'b0);
        localparam int         PB = pred_of(s, 1'b1);
        localparam logic [1:0] CA = code_of(in_bit_of(s), PA);
        localparam logic [1:0] CB = code_of(in_bit_of(s), PB);
        vit_acs_unit #(.W(W)) u_acs (
            .pm_a   (pm_q[PA]),
            .pm_b   (pm_q[PB]),
            .bm_a   (bm[CA]),
            .bm_b   (bm[CB]),
            .pm_new (pm_d[s]),
            .pick   (pick[s])
        );
    end

    vit_survivor #(.DEPTH(DEPTH)) u_surv (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .pick  (pick),
        .rows  (rows)
    );

    // Path metric registers: seeded at reset, loaded on each symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSTATE; s++)
                pm_q[s] <= (s == 0) ? '0 : W'(INIT_OFFSET);
        end else if (in_valid) begin
            for (int s = 0; s < NSTATE; s++) pm_q[s] <= pm_d[s];
        end
    end

    // Count accepted symbols up to the decision depth; remember acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid && cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Best state by modular compare; ties stay with the lower state number.
    always_comb begin
        best     = '0;
        best_gap = '0;
        for (int s = 1; s < NSTATE; s++) begin
            best_gap = pm_q[s] - pm_q[best];
            if (best_gap[W-1]) best = MEM'(s);
        end
    end

    // Output the oldest decision of the best survivor.
    always_comb begin
        out_valid = valid_q && (cnt_q == CW'(DEPTH));
        out_bit   = rows[best][DEPTH-1];
    end
endmodule

// File: rtl/vit_decoder_chk.sv
// Property checker for vit_decoder, attached by bind. It watches output
// timing, idle behaviour and the bound on the wrapping metric spread.
module vit_decoder_chk #(
    parameter int W  = 4,
    parameter int NS = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic         out_bit,
    input logic [W-1:0] pm_q [NS]
);
    localparam int SPREAD_MAX = 6;

    // R5: a decoded bit appears only right after an accepted symbol.
    a_r5_valid_after_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R6: an idle cycle leaves the decoded output bit untouched.
    a_r6_idle_keeps_output: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_bit));

    for (genvar i = 0; i < NS; i++) begin : g_idle
        // R6: an idle cycle leaves every path metric untouched.
        a_r6_idle_keeps_metric: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(pm_q[i]));

        for (genvar j = i + 1; j < NS; j++) begin : g_pair
            logic [W-1:0] gap;
            assign gap = pm_q[i] - pm_q[j];
            // R3: modular difference stays within the spread bound.
            a_r3_spread_bounded: assert property (@(posedge clk) disable iff (!rst_n)
                ($signed(gap) <= SPREAD_MAX) && ($signed(gap) >= -SPREAD_MAX));
        end
    end
endmodule

bind vit_decoder vit_decoder_chk #(.W(W), .NS(vit_pkg::NSTATE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .pm_q      (pm_q)
);

// File: tb/vit_decoder_test.sv
// Bench for vit_decoder: behavioural integer-metric Viterbi model with
// full survivor queues, compared with the outputs on every falling edge.
module vit_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_sym = 2'b00;
    logic       out_valid, out_bit;

    always #10 clk = ~clk;

    vit_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    int    checks = 0, fails = 0;
    bit    done = 0;
    int    mpm [4];
    bit    mpath [4][$];
    bit    truth [$];
    int    mcount, enc;
    bit    exp_valid, exp_bit, exp_truth, truth_on;
    string truth_tag;

    function automatic bit [1:0] pair_for(int u, int prev);
        int s1 = (prev >> 1) & 1;
        int s0 = prev & 1;
        return {1'(u ^ s1 ^ s0), 1'(u ^ s0)};
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic model_reset();
        mpm = '{0, 4, 4, 4};
        for (int n = 0; n < 4; n++) mpath[n].delete();
        truth.delete();
        mcount = 0; enc = 0; exp_valid = 0; exp_bit = 0; exp_truth = 0;
    endtask

    task automatic model_step(bit [1:0] rx, bit u_true);
        int npm [4];
        int from [4];
        bit np [4][$];
        int best;
        for (int n = 0; n < 4; n++) begin
            int u  = n / 2;
            int p0 = (n * 2) % 4;
            int c0 = mpm[p0] + $countones(rx ^ pair_for(u, p0));
            int c1 = mpm[p0 + 1] + $countones(rx ^ pair_for(u, p0 + 1));
            if (c1 < c0) begin npm[n] = c1; from[n] = p0 + 1; end
            else         begin npm[n] = c0; from[n] = p0;     end
        end
        for (int n = 0; n < 4; n++) begin
            np[n] = mpath[from[n]];
            np[n].push_back(bit'(n / 2));
        end
        for (int n = 0; n < 4; n++) begin
            mpath[n] = np[n];
            mpm[n] = npm[n];
        end
        truth.push_back(u_true);
        mcount++;
        if (mcount >= 12) begin
            best = 0;
            for (int n = 1; n < 4; n++) if (mpm[n] < mpm[best]) best = n;
            exp_valid = 1;
            exp_bit   = mpath[best][mcount - 12];
            exp_truth = truth[mcount - 12];
        end else begin
            exp_valid = 0;
        end
    endtask

    // One cycle: compare outputs due now, then drive and advance the model.
    task automatic cycle(bit v, bit [1:0] rx, bit u_true);
        @(negedge clk);
        check(out_valid === exp_valid, "R5 out_valid timing", out_valid, exp_valid);
        if (exp_valid && out_valid) begin
            check(out_bit === exp_bit, "R3 R4 R7 R8 model decision", out_bit, exp_bit);
            if (truth_on)
                check(out_bit === exp_truth, truth_tag, out_bit, exp_truth);
        end
        in_valid = v;
        in_sym   = rx;
        if (v) model_step(rx, u_true);
        else   exp_valid = 0;
    endtask

    task automatic send(bit u, bit [1:0] flip, int gap);
        bit [1:0] rx = pair_for(u, enc) ^ flip;
        enc = ((int'(u) << 1) | (enc >> 1)) & 3;
        cycle(1'b1, rx, u);
        for (int g = 0; g < gap; g++) cycle(1'b0, 2'b00, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; in_sym = 0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R4 out_valid low in reset", out_valid, 0);
        model_reset();
        rst_n = 1;
        @(negedge clk);
        check(out_valid === 1'b0, "R4 out_valid low after reset", out_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1 R8: clean stream decodes to the encoder input, delayed.
        do_reset();
        truth_on = 1; truth_tag = "R1 R8 clean decode";
        for (int i = 0; i < 80; i++) send(bit'($urandom % 2), 2'b00, 0);
        // R2: isolated single-bit errors are corrected.
        do_reset();
        truth_on = 1; truth_tag = "R2 isolated error corrected";
        for (int i = 0; i < 120; i++)
            send(bit'($urandom % 2), (i % 20 == 10) ? ((i % 40 == 10) ? 2'b01 : 2'b10) : 2'b00, 0);
        // R3 R7: noisy stream with many ties and wrapping metrics.
        do_reset();
        truth_on = 0;
        for (int i = 0; i < 400; i++) begin
            bit [1:0] f = {bit'($urandom % 6 == 0), bit'($urandom % 6 == 0)};
            send(bit'($urandom % 2), f, 0);
        end
        // R3: fully random symbols keep the metrics wrapping.
        do_reset();
        for (int i = 0; i < 200; i++) cycle(1'b1, 2'($urandom % 4), 1'b0);
        cycle(1'b0, 2'b00, 1'b0);
        // R6: idle gaps do not disturb decoding.
        do_reset();
        truth_on = 1; truth_tag = "R6 decode across idle gaps";
        for (int i = 0; i < 80; i++) send(bit'($urandom % 2), 2'b00, int'($urandom % 4));
        cycle(1'b0, 2'b00, 1'b0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule